// File: doc/BRIEF.md
# Staged Clock Output Divider Bank

A bank of clock output channels that derive slower clocks from one input clock. Each channel counts a programmable number of input cycles high and then a programmable number low. A channel can instead pass the input clock straight through for a ratio of one, or it can hold its output at zero. Software programs the bank through a simple write port. Each write goes into a staging copy of the setting. The staged settings move into the working settings only after a commit write.

Each channel takes its committed settings at its own next period boundary, so the output never shows a shortened pulse. A separate sync control holds every channel low while it is set. When it is cleared, all channels restart their counting on the same edge. This lines up the phases of outputs that run at different ratios.

Top module: `clkdiv_bank`

## Requirements
- R1: Channel c has a ratio register at address 4c. Bits [3:0] give H and bits [7:4] give L. The output is high for H+1 input cycles and then low for L+1 input cycles, repeating with a period of H+L+2.
- R2: When bit 7 of the register at address 4c+1 is committed as 1, the divider is skipped and the channel output follows the input clock.
- R3: When bit 0 of the register at address 4c+2 is committed as 1, the channel output stays at 0. The divider keeps running.
- R4: Writes to the per-channel registers change nothing at the outputs until they are committed. A write to address 0xF0 with bit 0 clear is ignored.
- R5: A write to address 0xF0 with bit 0 set commits the staged settings. Each channel loads them on the first edge after the commit write at which its current period ends. The old period always completes first.
- R6: While bit 2 of the register at address 0xF1 is 1, all outputs are 0. From the edge that clears the bit, every channel starts together at the first cycle of its high phase.
- R7: A write to address 0xF1 that leaves bit 2 at 0 when it was already 0 does not disturb any channel's phase.
- R8: While rst_n is low, all outputs are 0. After reset, every channel divides by 2, is enabled and is not bypassed. Each channel starts high on the cycle in which reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | 8 | Register write data |
| clk_o | output | NCH | Divided clock outputs, one per channel |

## Verification
A write takes effect on the rising edge that captures it. A sync set forces the outputs low from just after that edge. A sync clear puts every channel into its first high cycle from just after the clearing edge. A commit write reaches a channel only on the first later edge at which that channel's period ends, so the bench works out that edge from the period that is running. The bench samples every output 1 ns after each rising edge and compares it with the level that its cycle count since the last alignment predicts. Bypassed channels are also sampled after the falling edge, to show that the output follows the input clock low as well as high.

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NCH = 3,
  parameter int AW = 8,
  parameter logic [AW-1:0] UPD_ADDR = 8'hF0,
  parameter logic [AW-1:0] SYNC_ADDR = 8'hF1
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  output logic [NCH-1:0] clk_o
);

  logic                 sync_hold;
  logic [NCH-1:0][7:0]  stg_div, act_div;
  logic [NCH-1:0][3:0]  cnt;
  logic [NCH-1:0]       stg_byp, act_byp, stg_off, act_off, pend, ph, bnd;

  wire upd_hit = wr_en && (wr_addr == UPD_ADDR) && wr_data[0];

  always_ff @(posedge clk_i or negedge rst_n)
    if (!rst_n) sync_hold <= 1'b0;
    else if (wr_en && wr_addr == SYNC_ADDR) sync_hold <= wr_data[2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_DIV = AW'(4 * c);
    localparam logic [AW-1:0] A_CTL = AW'(4 * c + 1);
    localparam logic [AW-1:0] A_OUT = AW'(4 * c + 2);

    wire [3:0] hi_n = act_div[c][3:0];
    wire [3:0] lo_n = act_div[c][7:4];

    assign bnd[c] = sync_hold | act_byp[c] | (!ph[c] && cnt[c] == lo_n);

    always_ff @(posedge clk_i or negedge rst_n)
      if (!rst_n) begin
        stg_div[c] <= 8'h00;
        stg_byp[c] <= 1'b0;
        stg_off[c] <= 1'b0;
      end else if (wr_en) begin
        if (wr_addr == A_DIV) stg_div[c] <= wr_data;
        if (wr_addr == A_CTL) stg_byp[c] <= wr_data[7];
        if (wr_addr == A_OUT) stg_off[c] <= wr_data[0];
      end

    always_ff @(posedge clk_i or negedge rst_n)
      if (!rst_n) pend[c] <= 1'b0;
      else if (upd_hit) pend[c] <= 1'b1;
      else if (bnd[c]) pend[c] <= 1'b0;

    always_ff @(posedge clk_i or negedge rst_n)
      if (!rst_n) begin
        act_div[c] <= 8'h00;
        act_byp[c] <= 1'b0;
        act_off[c] <= 1'b0;
      end else if (pend[c] && bnd[c]) begin
        act_div[c] <= stg_div[c];
        act_byp[c] <= stg_byp[c];
        act_off[c] <= stg_off[c];
      end

    always_ff @(posedge clk_i or negedge rst_n)
      if (!rst_n) begin
        ph[c]  <= 1'b1;
        cnt[c] <= '0;
      end else if (bnd[c]) begin
        ph[c]  <= 1'b1;
        cnt[c] <= '0;
      end else if (ph[c] && cnt[c] == hi_n) begin
        ph[c]  <= 1'b0;
        cnt[c] <= '0;
      end else begin
        cnt[c] <= cnt[c] + 4'd1;
      end

    assign clk_o[c] = rst_n & ~sync_hold & ~act_off[c] & (act_byp[c] ? clk_i : ph[c]);
  end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NCH = 3,
  parameter int AW = 8,
  parameter logic [AW-1:0] SYNC_ADDR = 8'hF1
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic [7:0]          wr_data,
  input logic [NCH-1:0]      clk_o,
  input logic                sync_hold,
  input logic [NCH-1:0]      ph,
  input logic [NCH-1:0][3:0] cnt,
  input logic [NCH-1:0][7:0] act_div,
  input logic [NCH-1:0]      act_byp,
  input logic [NCH-1:0]      act_off,
  input logic [NCH-1:0]      pend,
  input logic [NCH-1:0]      bnd
);

  always @(negedge clk_i)
    if (rst_n === 1'b0)
      a_r8_reset_low: assert (clk_o == '0);

  a_r6_sync_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en && wr_addr == SYNC_ADDR && wr_data[2]) |=> (clk_o == '0));

  a_r6_restart_aligned: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(sync_hold) && !sync_hold) |-> (&ph));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r1_high_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
      (ph[c] && !act_byp[c]) |-> (cnt[c] <= act_div[c][3:0]));

    a_r1_low_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!ph[c]) |-> (cnt[c] <= act_div[c][7:4]));

    a_r4_active_frozen: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!pend[c]) |=> $stable({act_div[c], act_byp[c], act_off[c]}));

    a_r5_load_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!$stable({act_div[c], act_byp[c], act_off[c]})) |-> $past(bnd[c]));
  end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NCH(NCH), .AW(AW), .SYNC_ADDR(SYNC_ADDR)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .clk_o(clk_o), .sync_hold(sync_hold), .ph(ph), .cnt(cnt), .act_div(act_div),
  .act_byp(act_byp), .act_off(act_off), .pend(pend), .bnd(bnd));

// File: tb/clkdiv_bank_bench.sv
`timescale 1ns/1ps
module clkdiv_bank_bench;
  localparam int NCH = 3;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [NCH-1:0] clk_o;

  clkdiv_bank #(.NCH(NCH)) u_clkdiv_bank (
    .clk_i(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clk_o(clk_o));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit hold = 0, in_rst = 1, done = 0;
  string tag = "";
  int cur_h[NCH], cur_l[NCH], nxt_h[NCH], nxt_l[NCH], stg_h[NCH], stg_l[NCH];
  bit cur_b[NCH], cur_o[NCH], nxt_b[NCH], nxt_o[NCH], stg_b[NCH], stg_o[NCH];
  int t0[NCH], sw[NCH];

  function automatic bit exp_bit(int h, int l, bit b, bit o, int k);
    if (o) return 1'b0;
    if (b) return 1'b1;
    return (k % (h + l + 2)) < (h + 1);
  endfunction

  function automatic int period(int c);
    return cur_b[c] ? 1 : cur_h[c] + cur_l[c] + 2;
  endfunction

  task automatic report(string t, int c, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ch%0d cyc %0d got %b expected %b", t, c, cyc, got, exp);
    end
  endtask

  task automatic apply_write();
    if (!wr_en) return;
    for (int c = 0; c < NCH; c++) begin
      if (wr_addr == 8'(4*c))   begin stg_h[c] = wr_data[3:0]; stg_l[c] = wr_data[7:4]; end
      if (wr_addr == 8'(4*c+1)) stg_b[c] = wr_data[7];
      if (wr_addr == 8'(4*c+2)) stg_o[c] = wr_data[0];
    end
    if (wr_addr == 8'hF0 && wr_data[0])
      for (int c = 0; c < NCH; c++) begin
        if (hold) begin
          cur_h[c] = stg_h[c]; cur_l[c] = stg_l[c]; cur_b[c] = stg_b[c]; cur_o[c] = stg_o[c];
          sw[c] = -1;
        end else begin
          nxt_h[c] = stg_h[c]; nxt_l[c] = stg_l[c]; nxt_b[c] = stg_b[c]; nxt_o[c] = stg_o[c];
          sw[c] = t0[c] + period(c) * ((cyc - t0[c]) / period(c) + 1);
        end
      end
    if (wr_addr == 8'hF1) begin
      if (wr_data[2]) hold = 1;
      else if (hold) begin
        hold = 0;
        for (int c = 0; c < NCH; c++) t0[c] = cyc;
      end
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cyc++;
    apply_write();
    for (int c = 0; c < NCH; c++) begin
      string t;
      bit e;
      if (sw[c] >= 0 && cyc >= sw[c]) begin
        cur_h[c] = nxt_h[c]; cur_l[c] = nxt_l[c]; cur_b[c] = nxt_b[c]; cur_o[c] = nxt_o[c];
        t0[c] = sw[c]; sw[c] = -1;
      end
      e = (in_rst || hold) ? 1'b0 : exp_bit(cur_h[c], cur_l[c], cur_b[c], cur_o[c], cyc - t0[c]);
      if (tag != "") t = tag;
      else if (cur_o[c]) t = "R3";
      else if (cur_b[c]) t = "R2";
      else t = "R1";
      report(t, c, clk_o[c], e);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired at cyc %0d", cyc);
    finish_run();
  end

  initial begin
    int seed;
    for (int c = 0; c < NCH; c++) begin
      cur_h[c] = 0; cur_l[c] = 0; cur_b[c] = 0; cur_o[c] = 0;
      stg_h[c] = 0; stg_l[c] = 0; stg_b[c] = 0; stg_o[c] = 0;
      t0[c] = 0; sw[c] = -1;
    end
    seed = $urandom(32'd2024);

    tag = "R8";
    run(4);
    rst_n = 1'b1; in_rst = 0;
    for (int c = 0; c < NCH; c++) t0[c] = cyc;
    run(10);

    tag = "R4";
    wr(8'h00, 8'h33);
    wr(8'h05, 8'h80);
    run(8);
    wr(8'hF0, 8'h00);
    run(8);

    tag = "R5";
    run(1);
    wr(8'hF0, 8'h01);
    run(30);

    tag = "R2";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #0.5;
      report("R2", 1, clk_o[1], 1'b0);
      step();
    end

    tag = "R6";
    wr(8'hF1, 8'h04);
    run(5);
    wr(8'hF1, 8'h04);
    wr(8'hF1, 8'h00);
    run(20);

    tag = "R7";
    run(3);
    wr(8'hF1, 8'h00);
    wr(8'hF1, 8'h00);
    run(20);

    tag = "R3";
    wr(8'h0A, 8'h01);
    wr(8'hF0, 8'h01);
    run(20);

    tag = "R1";
    wr(8'h00, 8'h52);
    wr(8'h05, 8'h00);
    wr(8'h0A, 8'h00);
    wr(8'hF1, 8'h04);
    wr(8'hF0, 8'h01);
    wr(8'hF1, 8'h00);
    run(30);

    tag = "";
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [3:0] h, l;
        h = 4'($urandom_range(0, 15));
        l = ($urandom_range(0, 1) == 0) ? h : 4'($urandom_range(0, 15));
        wr(8'(4*c), {l, h});
        wr(8'(4*c+1), ($urandom_range(0, 4) == 0) ? 8'h80 : 8'h00);
        wr(8'(4*c+2), ($urandom_range(0, 5) == 0) ? 8'h01 : 8'h00);
      end
      if (r % 2 == 0) begin
        wr(8'hF1, 8'h04);
        wr(8'hF0, 8'h01);
        wr(8'hF1, 8'h00);
      end else begin
        wr(8'hF0, 8'h01);
      end
      run(40);
    end

    finish_run();
  end
endmodule